// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Unit

This block is a watchdog timer whose configuration and status can only be changed after a two-step key handshake. Software writes a first key word and then a second key word to two dedicated addresses. This opens the lock for exactly one write to a guarded register: the control bits, the match value or the event flag. Any write after that closes the lock again, so the handshake must be repeated before each guarded write.

While either enable bit is set, the counter advances once per `tick`. When a tick brings the count equal to the programmed match value, the unit records an event. Depending on the control bits, it then drives a fixed-length system reset request pulse, raises a level interrupt, or does both. Writing the control register restarts the count from zero. A single combinational read port returns the registers, the live count and the lock state.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, control reads 0, match reads 0xFFFF, count reads 0, status reads 0, the lock is closed, and `reset_req` and `irq` are low.
- R2: Writing 0x0000BABA to address 4 and then 0x0000EB10 to address 5 opens the lock. Status bit 1 reads 1 while the lock is open.
- R3: Any other write while the handshake is pending returns the lock to closed. This covers a wrong value, a wrong address, or the second key without the first. A write of 0x0000BABA to address 4 always restarts the handshake at its second step.
- R4: The guarded registers are control (address 0), match (address 1) and status (address 3). A write to any of them takes effect only while the lock is open, and is ignored otherwise.
- R5: Any single write made while the lock is open closes it, so a second guarded write without a new handshake is ignored.
- R6: Control bit 0 enables the interrupt and bit 1 enables the reset request. A write to control clears the count to 0. The count (address 2, read-only) rises by one on each tick while either bit is set, and holds while both bits are 0.
- R7: When a tick brings the count equal to the match value with an enable bit set, status bit 0 is set. It becomes visible in the same cycle that the count shows the match value.
- R8: With control bit 1 set, a match drives `reset_req` high for exactly 4 cycles, beginning in the cycle that the count shows the match value. With bit 1 clear, `reset_req` stays low.
- R9: `irq` is high exactly while status bit 0 and control bit 0 are both 1.
- R10: A guarded write to status with data bit 0 equal to 0 clears the event. With data bit 0 equal to 1, the event is left unchanged. A match in the same cycle takes priority over the clear.
- R11: Reads of the key addresses 4 and 5 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count step strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| reset_req | output | 1 | System reset request pulse |
| irq | output | 1 | Watchdog interrupt (level) |

## Verification
A lock stuck open shows up on the status read at once. It also lets the next unkeyed match write land, which the following match read-back exposes. A lock that fails to open leaves the match value at its reset value, and that is seen one write later. A wrong count or comparison moves the match event by at least one tick, which the per-tick count and `reset_req` samples catch in that same cycle. A wrong pulse length is measured cycle by cycle.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t A_CTRL   = 3'd0;
  localparam addr_t A_MATCH  = 3'd1;
  localparam addr_t A_COUNT  = 3'd2;
  localparam addr_t A_STATUS = 3'd3;
  localparam addr_t A_KEY1   = 3'd4;
  localparam addr_t A_KEY2   = 3'd5;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_t;

  function automatic logic is_guarded(input addr_t a);
    return (a == A_CTRL) || (a == A_MATCH) || (a == A_STATUS);
  endfunction
endpackage

// File: rtl/wdk_unlock.sv
module wdk_unlock
  import keyed_watchdog_pkg::*;
#(
  parameter data_t KEY_A = 32'h0000_BABA,
  parameter data_t KEY_B = 32'h0000_EB10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t addr,
  input  data_t wdata,
  output logic  open_q
);
  lock_t state_q, state_d;

  function automatic lock_t f_next(input lock_t s, input addr_t a, input data_t d);
    if (a == A_KEY1 && d == KEY_A) return LK_HALF;
    if (s == LK_HALF && a == A_KEY2 && d == KEY_B) return LK_OPEN;
    return LK_CLOSED;
  endfunction

  always_comb begin
    state_d = state_q;
    if (wr_en) state_d = f_next(state_q, addr, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_CLOSED;
    else        state_q <= state_d;
  end

  assign open_q = (state_q == LK_OPEN);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             clear,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  function automatic logic [CNT_W-1:0] f_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  assign hit = tick && en && !clear && (f_step(cnt_q) == match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear)     cnt_q <= '0;
    else if (tick && en) cnt_q <= f_step(cnt_q);
  end
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rem_q <= '0;
    else if (fire)          rem_q <= PW'(PULSE_LEN);
    else if (rem_q != '0)   rem_q <= rem_q - 1'b1;
  end

  assign active = (rem_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PULSE_LEN = 4,
  parameter data_t       KEY_A     = 32'h0000_BABA,
  parameter data_t       KEY_B     = 32'h0000_EB10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        reset_req,
  output logic        irq
);
  logic             open_q;
  logic             hit;
  logic [1:0]       ctrl_q;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cnt_q;
  logic             evt_q;
  logic             gwr, ctrl_wr, match_wr, status_wr;

  wdk_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .open_q(open_q)
  );

  assign gwr       = wr_en && open_q && is_guarded(addr);
  assign ctrl_wr   = gwr && (addr == A_CTRL);
  assign match_wr  = gwr && (addr == A_MATCH);
  assign status_wr = gwr && (addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '1;
    end else begin
      if (ctrl_wr)  ctrl_q  <= wdata[1:0];
      if (match_wr) match_q <= wdata[CNT_W-1:0];
    end
  end

  wdk_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(|ctrl_q), .clear(ctrl_wr),
    .match(match_q), .cnt_q(cnt_q), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      evt_q <= 1'b0;
    else if (hit)                    evt_q <= 1'b1;
    else if (status_wr && !wdata[0]) evt_q <= 1'b0;
  end

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(hit && ctrl_q[1]), .active(reset_req)
  );

  assign irq = evt_q && ctrl_q[0];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata = DATA_W'(ctrl_q);
      A_MATCH:  rdata = DATA_W'(match_q);
      A_COUNT:  rdata = DATA_W'(cnt_q);
      A_STATUS: rdata = DATA_W'({open_q, evt_q});
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PULSE_LEN = 4,
  parameter data_t       KEY_B     = 32'h0000_EB10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             reset_req,
  input logic             irq,
  input logic             open_q,
  input logic             hit,
  input logic             evt_q,
  input logic [1:0]       ctrl_q,
  input logic [CNT_W-1:0] match_q
);
  localparam int unsigned SW = $clog2(PULSE_LEN + 2);
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_q <= SW'(PULSE_LEN + 1);
    else if (hit && ctrl_q[1])            since_q <= SW'(1);
    else if (since_q != SW'(PULSE_LEN + 1)) since_q <= since_q + 1'b1;
  end

  // R11
  key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_KEY1 || addr == A_KEY2) |-> rdata == '0);

  // R4
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MATCH && !open_q) |=> $stable(match_q));

  // R2
  unlock_needs_key2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(wr_en && addr == A_KEY2 && wdata == KEY_B));

  // R5
  unlock_single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && wr_en && addr != A_KEY1) |=> !open_q);

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req == (since_q != '0 && since_q <= SW'(PULSE_LEN)));

  // R7
  hit_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt_q);

  // R9
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_q);
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .KEY_B(KEY_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .reset_req(reset_req), .irq(irq), .open_q(open_q), .hit(hit), .evt_q(evt_q),
  .ctrl_q(ctrl_q), .match_q(match_q)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        reset_req, irq;
  int          n_run = 0;
  int          n_fail = 0;
  int          cyc = 0;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .reset_req(reset_req), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run = n_run + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic unlock();
    wr(3'd4, 32'h0000_BABA);
    wr(3'd5, 32'h0000_EB10);
  endtask

  task automatic gwrite(input logic [2:0] a, input logic [31:0] d);
    unlock();
    wr(a, d);
  endtask

  task automatic step();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (reset_req && n < 12) begin
      n = n + 1;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] v;
    int          n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd1, v); check("R1 match", v, 32'hFFFF);
    rd(3'd2, v); check("R1 count", v, 32'h0);
    rd(3'd3, v); check("R1 status", v, 32'h0);
    check("R1 reset_req", {31'b0, reset_req}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R11 key reads
    rd(3'd4, v); check("R11 key1 read", v, 32'h0);
    rd(3'd5, v); check("R11 key2 read", v, 32'h0);

    // R4 locked write ignored
    wr(3'd1, 32'h0000_0007);
    rd(3'd1, v); check("R4 locked match write", v, 32'hFFFF);

    // R2 unlock
    unlock();
    rd(3'd3, v); check("R2 lock open", v, 32'h2);
    rd(3'd4, v); check("R11 key1 read while open", v, 32'h0);
    wr(3'd1, 32'h0000_0005);
    rd(3'd1, v); check("R4 unlocked match write", v, 32'h5);
    rd(3'd3, v); check("R5 lock closed after write", v, 32'h0);
    wr(3'd1, 32'h0000_0009);
    rd(3'd1, v); check("R5 second write ignored", v, 32'h5);

    // R3 bad sequences
    wr(3'd4, 32'h0000_BABB); wr(3'd5, 32'h0000_EB10);
    rd(3'd3, v); check("R3 wrong key1", v, 32'h0);
    wr(3'd4, 32'h0000_BABA); wr(3'd5, 32'h0000_EB11);
    rd(3'd3, v); check("R3 wrong key2", v, 32'h0);
    wr(3'd5, 32'h0000_EB10);
    rd(3'd3, v); check("R3 key2 alone", v, 32'h0);
    wr(3'd4, 32'h0000_BABA); wr(3'd2, 32'h0); wr(3'd5, 32'h0000_EB10);
    rd(3'd3, v); check("R3 interposed write", v, 32'h0);
    wr(3'd5, 32'h0000_EB10); wr(3'd4, 32'h0000_BABA);
    rd(3'd3, v); check("R3 reversed order", v, 32'h0);
    wr(3'd5, 32'h0000_EB10);
    rd(3'd3, v); check("R3 reversed then key2 opens", v, 32'h2);
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h0000_BABA); wr(3'd4, 32'h0000_BABA); wr(3'd5, 32'h0000_EB10);
    rd(3'd3, v); check("R3 key1 restart", v, 32'h2);
    wr(3'd2, 32'h0);

    // R6 no count while disabled
    repeat (3) step();
    rd(3'd2, v); check("R6 hold when ctrl=0", v, 32'h0);

    // R7 R8 R9 sweep of match values, both enables
    for (int m = 1; m <= 6; m++) begin
      gwrite(3'd1, 32'(m));
      gwrite(3'd0, 32'h3);
      rd(3'd2, v); check("R6 ctrl write clears count", v, 32'h0);
      for (int k = 1; k <= m; k++) begin
        step();
        rd(3'd2, v); check("R6 count step", v, 32'(k));
        rd(3'd3, v); check("R7 status at step", v, (k == m) ? 32'h1 : 32'h0);
        if (k < m) check("R8 no early reset", {31'b0, reset_req}, 32'h0);
      end
      check("R9 irq after match", {31'b0, irq}, 32'h1);
      pulse_len(n); check("R8 pulse length", 32'(n), 32'd4);
      step();
      rd(3'd2, v); check("R6 count past match", v, 32'(m + 1));
      check("R8 no repeat", {31'b0, reset_req}, 32'h0);
      gwrite(3'd3, 32'h1);
      rd(3'd3, v); check("R10 write 1 keeps event", v, 32'h1);
      gwrite(3'd3, 32'h0);
      rd(3'd3, v); check("R10 write 0 clears event", v, 32'h0);
      check("R9 irq cleared", {31'b0, irq}, 32'h0);
    end

    // R8 R9 reset only
    gwrite(3'd1, 32'h3);
    gwrite(3'd0, 32'h2);
    repeat (3) step();
    rd(3'd3, v); check("R7 status reset-only", v, 32'h1);
    check("R9 no irq reset-only", {31'b0, irq}, 32'h0);
    pulse_len(n); check("R8 pulse reset-only", 32'(n), 32'd4);
    gwrite(3'd3, 32'h0);

    // R8 R9 interrupt only
    gwrite(3'd0, 32'h1);
    n = 0;
    for (int k = 0; k < 3; k++) begin
      step();
      if (reset_req) n = n + 1;
    end
    repeat (4) begin
      @(negedge clk);
      if (reset_req) n = n + 1;
    end
    rd(3'd3, v); check("R7 status irq-only", v, 32'h1);
    check("R9 irq irq-only", {31'b0, irq}, 32'h1);
    check("R8 no reset irq-only", 32'(n), 32'd0);

    // R6 mid-count clear
    gwrite(3'd3, 32'h0);
    gwrite(3'd1, 32'h20);
    gwrite(3'd0, 32'h1);
    repeat (5) step();
    rd(3'd2, v); check("R6 counted", v, 32'h5);
    gwrite(3'd0, 32'h1);
    rd(3'd2, v); check("R6 cleared mid-count", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule